// File: doc/BRIEF.md
# Numerically Controlled Rate Generator

This block derives a slower, programmable rate from the reference clock it runs on. A phase accumulator adds a step value on every reference cycle. Each time the accumulator wraps, the block emits a one-cycle tick that a downstream counter can use as a clock enable. The most significant accumulator bit is also brought out as a square wave at the same rate. The synthesized frequency is the step times the reference frequency divided by 2^16.

Software loads the 16-bit rate word as two byte writes: the high byte first, then the low byte. The low-byte write commits the whole word at once, so the accumulator never runs on a half-updated value.

Words at or above 2^15 are not used directly. Each one is replaced by its 16-bit two's complement, so the usable step runs from 1 to 32768. A step that is a power of two gives a square output with exactly equal high and low times. A zero word parks the block: no ticks, and the square output stays low.

Top module: `nco_clkgen`

## Requirements
- R1: A write with `wr_hi` high stores `wr_data` as the pending upper byte. A later write with `wr_lo` high makes the active word {pending upper byte, `wr_data`}. The new word takes effect in the accumulator on the first clock edge after the commit edge.
- R2: A write with only `wr_hi` high leaves the active word unchanged. Tick and square outputs keep following the previous word.
- R3: When `wr_hi` and `wr_lo` are high in the same cycle, the active word becomes {`wr_data`, `wr_data`}.
- R4: The step is W = word when word < 0x8000, and W = 0x10000 − word otherwise. For example, 0xC000 gives 0x4000, 0xFFFF gives 1 and 0x8000 gives 0x8000.
- R5: With a nonzero step, the 16-bit phase grows by W, modulo 2^16, on every clock edge. `square_out` is bit 15 of the phase.
- R6: `tick` is high for exactly one cycle after each edge where the phase addition carries out of bit 15. Starting from phase 0, n edges with step W give exactly floor(n·W/2^16) ticks.
- R7: A step of 2^k gives a square wave of period 2^(16−k) cycles, high for exactly half of them. A step of 0x8000 toggles `square_out` on every cycle and ticks on every second cycle.
- R8: An active word of zero clears the phase on the next edge. It then keeps `tick` and `square_out` low.
- R9: A synchronous reset (`rst` high at a clock edge) clears the active word, the pending upper byte, the phase and `tick`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_hi | input | 1 | Strobe: store `wr_data` as the pending upper byte |
| wr_lo | input | 1 | Strobe: store `wr_data` as the lower byte and commit the word |
| wr_data | input | WORD_W/2 | Byte being written |
| tick | output | 1 | One-cycle pulse on each phase wrap |
| square_out | output | 1 | Phase MSB, a square wave at the synthesized rate |

## Verification
The bench builds the block with its default 16-bit word, so byte halves are 8 bits. At this width the slowest step, 1, wraps after 65,536 cycles. A full period of the slowest rate therefore fits in one run, and the single tick of a folded 0xFFFF word is checked at its exact cycle. The same width reaches the fold boundary at 0x8000 and its neighbours 0x7FFF and 0xC000. Every cycle of tick and square output is compared against a reference that tracks the unwrapped phase n·W and derives carries by integer division.

// File: rtl/nco_pkg.sv
package nco_pkg;
  // Fold a raw rate word into a step: words with the MSB set become their
  // two's complement within `width` bits.
  function automatic logic [31:0] fold_word(input logic [31:0] raw, input int unsigned width);
    logic [31:0] mask;
    logic [31:0] folded;
    mask = (32'd1 << width) - 32'd1;
    if (raw[width-1]) folded = ((32'd1 << width) - (raw & mask)) & mask;
    else              folded = raw & mask;
    return folded;
  endfunction
endpackage

// File: rtl/nco_word_reg.sv
module nco_word_reg #(
  parameter int HALF_W = 8,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [HALF_W-1:0] wr_data,
  output logic [WORD_W-1:0] word_o,
  output logic              commit_o
);
  logic [HALF_W-1:0] pend_hi;
  logic [HALF_W-1:0] upper_src;

  // A same-cycle upper write is folded straight into the commit.
  assign upper_src = wr_hi ? wr_data : pend_hi;
  assign commit_o  = wr_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_hi <= '0;
      word_o  <= '0;
    end else begin
      if (wr_hi) pend_hi <= wr_data;
      if (wr_lo) word_o  <= {upper_src, wr_data};
    end
  end
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] step,
  output logic [WORD_W-1:0] phase_o,
  output logic              wrap_o,
  output logic              tick_o
);
  logic [WORD_W:0] sum;

  assign sum    = {1'b0, phase_o} + {1'b0, step};
  assign wrap_o = sum[WORD_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_o <= '0;
      tick_o  <= 1'b0;
    end else if (step == '0) begin
      phase_o <= '0;
      tick_o  <= 1'b0;
    end else begin
      phase_o <= sum[WORD_W-1:0];
      tick_o  <= wrap_o;
    end
  end
endmodule

// File: rtl/nco_clkgen.sv
module nco_clkgen #(
  parameter int WORD_W = 16,
  localparam int HALF_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [HALF_W-1:0] wr_data,
  output logic              tick,
  output logic              square_out
);
  logic [WORD_W-1:0] active_word;
  logic              commit;
  logic [31:0]       folded32;
  logic [WORD_W-1:0] step;
  logic [WORD_W-1:0] phase;
  logic              wrap;

  nco_word_reg #(.HALF_W(HALF_W)) u_word (
    .clk      (clk),
    .rst      (rst),
    .wr_hi    (wr_hi),
    .wr_lo    (wr_lo),
    .wr_data  (wr_data),
    .word_o   (active_word),
    .commit_o (commit)
  );

  assign folded32 = nco_pkg::fold_word(32'(active_word), WORD_W);
  assign step     = folded32[WORD_W-1:0];

  nco_phase_acc #(.WORD_W(WORD_W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .phase_o (phase),
    .wrap_o  (wrap),
    .tick_o  (tick)
  );

  assign square_out = phase[WORD_W-1];
endmodule

// File: rtl/nco_clkgen_chk.sv
module nco_clkgen_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_lo,
  input logic              commit,
  input logic              wrap,
  input logic [WORD_W-1:0] active_word,
  input logic [WORD_W-1:0] step,
  input logic [WORD_W-1:0] phase,
  input logic              tick,
  input logic              square_out
);
  localparam logic [WORD_W-1:0] HALF_STEP = WORD_W'(1) << (WORD_W - 1);

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (active_word == '0 && phase == '0 && !tick));

  assert_word_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(active_word));

  assert_step_range_R4: assert property (@(posedge clk) disable iff (rst)
    step <= HALF_STEP);

  assert_phase_advance_R5: assert property (@(posedge clk) disable iff (rst)
    (step != '0) |=> (phase == WORD_W'($past(phase) + $past(step))));

  assert_tick_single_R6: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  assert_tick_follows_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (wrap && step != '0) |=> tick);

  assert_zero_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (step == '0) |=> (!tick && !square_out && phase == '0));

  assert_half_toggle_R7: assert property (@(posedge clk) disable iff (rst)
    (step == HALF_STEP && $past(step) == HALF_STEP && !wr_lo) |=> (square_out != $past(square_out)));
endmodule

bind nco_clkgen nco_clkgen_chk #(.WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_lo       (wr_lo),
  .commit      (commit),
  .wrap        (wrap),
  .active_word (active_word),
  .step        (step),
  .phase       (phase),
  .tick        (tick),
  .square_out  (square_out)
);

// File: tb/nco_clkgen_tb.sv
`timescale 1ns/1ps
module nco_clkgen_tb;
  localparam int WORD_W = 16;
  localparam int HALF_W = WORD_W / 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_hi = 1'b0;
  logic              wr_lo = 1'b0;
  logic [HALF_W-1:0] wr_data = '0;
  logic              tick;
  logic              square_out;

  int     checks = 0;
  int     errors = 0;
  bit     finished = 1'b0;
  longint t_m = 0;   // unwrapped reference phase

  always #2.5 clk = ~clk;

  nco_clkgen #(.WORD_W(WORD_W)) u_dut (
    .clk(clk), .rst(rst), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .wr_data(wr_data), .tick(tick), .square_out(square_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint ref_step(input longint w);
    return (w < 32768) ? w : 65536 - w;
  endfunction

  task automatic write_word(input logic [15:0] w);
    @(negedge clk); wr_hi = 1'b1; wr_data = w[15:8];
    @(negedge clk); wr_hi = 1'b0; wr_lo = 1'b1; wr_data = w[7:0];
    @(negedge clk); wr_lo = 1'b0;
  endtask

  task automatic zero_word();
    write_word(16'h0000);
    @(negedge clk);
    t_m = 0;
  endtask

  // Advance n cycles with step w, comparing every cycle against t_m.
  task automatic step_cmp(input longint w, input int n, input string req,
                          output longint ticks_seen, output longint highs_seen);
    int     bad = 0;
    longint fa = 0, fe = 0;
    ticks_seen = 0;
    highs_seen = 0;
    for (int k = 0; k < n; k++) begin
      longint prev;
      bit te, se;
      @(negedge clk);
      prev = t_m;
      t_m  = t_m + w;
      te   = ((t_m / 65536) != (prev / 65536));
      se   = ((t_m / 32768) % 2) == 1;
      if (tick) ticks_seen++;
      if (square_out) highs_seen++;
      if (tick !== te || square_out !== se) begin
        if (bad == 0) begin
          fa = {tick, square_out};
          fe = {te, se};
        end
        bad++;
      end
    end
    check(bad == 0, req, "cycle trace {tick,square}", fa, fe);
  endtask

  task automatic run_word(input logic [15:0] w, input int n, input string req);
    longint tk, hi, sw;
    zero_word();
    write_word(w);
    sw = ref_step(longint'(w));
    step_cmp(sw, n, req, tk, hi);
    check(tk == (longint'(n) * sw) / 65536, req, "tick count", tk, (longint'(n) * sw) / 65536);
  endtask

  task automatic t_reset_state();
    longint tk, hi;
    repeat (3) @(negedge clk);
    check(tick == 1'b0, "R9", "tick in reset", tick, 0);
    check(square_out == 1'b0, "R9", "square in reset", square_out, 0);
    rst = 1'b0;
    t_m = 0;
    step_cmp(0, 50, "R8", tk, hi);
    check(tk == 0 && hi == 0, "R8", "activity with zero word", tk + hi, 0);
  endtask

  task automatic t_pow2();
    longint tk, hi;
    run_word(16'h8000, 64, "R7");
    zero_word();
    write_word(16'h0800);
    step_cmp(2048, 256, "R7", tk, hi);
    check(hi == 128, "R7", "square high cycles for step 0x0800", hi, 128);
    check(tk == 8, "R7", "ticks for step 0x0800", tk, 8);
  endtask

  task automatic t_hi_only();
    longint tk, hi;
    zero_word();
    write_word(16'h0400);
    step_cmp(1024, 10, "R2", tk, hi);
    wr_hi = 1'b1; wr_data = 8'h7F;
    step_cmp(1024, 1, "R2", tk, hi);
    wr_hi = 1'b0;
    step_cmp(1024, 40, "R2", tk, hi);
    wr_lo = 1'b1; wr_data = 8'h00;
    step_cmp(1024, 1, "R1", tk, hi);
    wr_lo = 1'b0;
    step_cmp(ref_step(32'h7F00), 400, "R1", tk, hi);
  endtask

  task automatic t_both();
    longint tk, hi;
    wr_hi = 1'b1; wr_lo = 1'b1; wr_data = 8'h05;
    step_cmp(ref_step(32'h7F00), 1, "R3", tk, hi);
    wr_hi = 1'b0; wr_lo = 1'b0;
    step_cmp(ref_step(32'h0505), 300, "R3", tk, hi);
  endtask

  task automatic t_mid_reset();
    longint tk, hi;
    rst = 1'b1;
    @(negedge clk);
    check(tick == 1'b0 && square_out == 1'b0, "R9", "outputs after mid-run reset",
          {tick, square_out}, 0);
    rst = 1'b0;
    t_m = 0;
    step_cmp(0, 60, "R9", tk, hi);
    check(tk == 0, "R9", "ticks after reset cleared word", tk, 0);
  endtask

  task automatic t_zero_after_run();
    longint tk, hi;
    zero_word();
    write_word(16'h3000);
    step_cmp(12288, 37, "R5", tk, hi);
    write_word(16'h0000);
    @(negedge clk);
    t_m = 0;
    step_cmp(0, 40, "R8", tk, hi);
    check(tk == 0 && hi == 0, "R8", "outputs after zero word", tk + hi, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin : main
    t_reset_state();
    run_word(16'h0123, 200, "R5");
    run_word(16'h7FFF, 300, "R6");
    t_pow2();
    run_word(16'hC000, 100, "R4");
    run_word(16'hFFFF, 65540, "R4");
    t_hi_only();
    t_both();
    t_zero_after_run();
    t_mid_reset();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule